// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is a single 16-bit down-counter channel with one output line whose waveform depends on the selected operating mode. It supports six modes: a terminal-count flag, a gate-triggered one-shot, a rate generator, a square-wave divider, a strobe started by loading a count, and a strobe started by a gate trigger. The counter clock is a plain input sampled in the system clock domain. Each rising edge seen on it is one counter tick.

Software selects a mode with a control write and then supplies the reload value as two byte writes. A chip-level wrapper instantiates the channel three times. A long delay is built by routing one channel's output into the next channel's counter-clock input.

Top module: `ictr_channel`

## Requirements
- R1: After reset the output is low, the mode is 0 and no count is held, so counter ticks leave the output low.
- R2: Count bytes are taken low byte first, then high byte. A write of only the low byte leaves the output unchanged. The reload value is copied into the counter on the first tick strictly after the high-byte write, and a tick in the same cycle as that write is not used. The counter changes only on a tick.
- R3: Mode 0 (code 0): a mode write or a high-byte write drives the output low. The output rises on the N-th tick after the load tick and stays high until the next mode or count write.
- R4: In modes 0, 2, 3 and 4 a low gate input suspends decrementing. Ticks while the gate is low do not advance the count.
- R5: Mode 1 (code 1): the output is high after a mode or count write. A falling gate edge arms a start. The next tick loads the count and drives the output low, and the output returns high N ticks after that load.
- R6: Mode 2 (code 2): the output is high, goes low for exactly one tick when the count reaches 1, and the count then reloads automatically. The period is N ticks.
- R7: Mode 3 (code 3): the output toggles each half period. For even N both halves last N/2 ticks. For odd N the high half lasts (N+1)/2 ticks and the low half lasts (N-1)/2 ticks.
- R8: Mode 4 (code 4): the output stays high and pulses low for one tick on the tick where the count reaches zero. It then stays high with no further pulse.
- R9: Mode 5 (code 5): same as mode 4, except the count is loaded on the first tick after a falling gate edge rather than after the count write.
- R10: A reload value of 0 counts as 65536 ticks.
- R11: A mode write with code 6 or 7 is ignored. Mode, output and count all carry on as before.
- R12: In modes 1 and 5, a falling gate edge while counting reloads the count on the next tick, which restarts the interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntClkIn | input | 1 | Counter clock level; each rising edge is one tick |
| gateIn | input | 1 | Gate: enable level in modes 0/2/3/4, falling-edge trigger in modes 1/5 |
| modeWr | input | 1 | Control write strobe |
| modeSel | input | 3 | Mode code 0..5 taken on modeWr |
| cntWr | input | 1 | Count byte write strobe |
| cntByte | input | 8 | Count byte, low byte first then high byte |
| cntOut | output | 1 | Channel output |

## Verification
Two things can land in one cycle: a counter-clock rising edge and the high-byte count write. The bench drives both on the same edge and then counts how many further ticks pass before the mode-0 output rises. If the extra tick were taken as the load, the output would rise one tick early. The other collision is a gate falling edge during a running one-shot. The bench judges it by checking that the output stays low for the full interval measured from the retrigger.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } modeE;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_RUN,
    PH_PULSE
  } phaseE;

  typedef struct packed {
    logic storeLo;
    logic storeHi;
    logic load;
    logic dec;
    logic square;
    logic highPhase;
  } dpCtlT;
endpackage

// File: rtl/ictr_datapath.sv
module ictr_datapath
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [CNT_W-1:0]  countVal,
  output logic              isOne,
  output logic              isTwo
);
  logic [BYTE_W-1:0] loByte;
  logic [CNT_W-1:0]  reloadVal;
  logic [CNT_W-1:0]  loadVal;
  logic [CNT_W-1:0]  step;

  // Odd reload in square mode: high half one longer, low half one shorter
  always_comb begin
    loadVal = reloadVal;
    if (ctl.square && reloadVal[0])
      loadVal = ctl.highPhase ? reloadVal + CNT_W'(1) : reloadVal - CNT_W'(1);
    step = ctl.square ? CNT_W'(2) : CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte    <= '0;
      reloadVal <= '0;
      countVal  <= '0;
    end else begin
      if (ctl.storeLo) loByte <= byteIn;
      if (ctl.storeHi) reloadVal <= {byteIn, loByte};
      if (ctl.load)     countVal <= loadVal;
      else if (ctl.dec) countVal <= countVal - step;
    end
  end

  assign isOne = (countVal == CNT_W'(1));
  assign isTwo = (countVal == CNT_W'(2));
endmodule

// File: rtl/ictr_control.sv
module ictr_control
  import ictr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntClkIn,
  input  logic       gateIn,
  input  logic       modeWr,
  input  logic [2:0] modeSel,
  input  logic       cntWr,
  input  logic       isOne,
  input  logic       isTwo,
  output dpCtlT      ctl,
  output logic       tick,
  output logic       outLevel
);
  logic  clkPrev, gatePrev, bytePtr, armed, trigPend, outReg;
  modeE  curMode;
  phaseE phase;

  logic  gateFall, modeAccept, loWrite, hiWrite, gatedMode, runEn;
  logic  nArmed, nTrig, nOut;
  phaseE nPhase;

  assign tick       = cntClkIn & ~clkPrev;
  assign gateFall   = gatePrev & ~gateIn;
  assign modeAccept = modeWr && (modeSel <= 3'd5);
  assign loWrite    = cntWr && !bytePtr && !modeAccept;
  assign hiWrite    = cntWr && bytePtr && !modeAccept;
  assign gatedMode  = (curMode == MD_ONESHOT) || (curMode == MD_HWSTROBE);
  assign runEn      = gatedMode || gateIn;

  always_comb begin
    ctl           = '0;
    ctl.storeLo   = loWrite;
    ctl.storeHi   = hiWrite;
    ctl.square    = (curMode == MD_SQUARE);
    ctl.highPhase = 1'b1;
    nPhase        = phase;
    nOut          = outReg;
    nArmed        = armed;
    nTrig         = gateFall ? 1'b1 : trigPend;
    if (modeAccept) begin
      nPhase = PH_IDLE;
      nOut   = (modeSel != 3'd0);
      nArmed = 1'b0;
      nTrig  = 1'b0;
    end else if (hiWrite) begin
      nOut = (curMode != MD_TERM);
      if (gatedMode) begin
        nPhase = PH_IDLE;
        nArmed = 1'b1;
        nTrig  = 1'b0;
      end else begin
        nPhase = PH_LOAD;
      end
    end else if (tick) begin
      if (gatedMode && armed && trigPend) begin
        ctl.load = 1'b1;
        nPhase   = PH_RUN;
        nOut     = (curMode == MD_HWSTROBE);
        nTrig    = gateFall;
      end else begin
        unique case (phase)
          PH_LOAD: begin
            ctl.load = 1'b1;
            nPhase   = PH_RUN;
          end
          PH_RUN: if (runEn) begin
            unique case (curMode)
              MD_TERM, MD_ONESHOT: begin
                ctl.dec = 1'b1;
                if (isOne) begin
                  nOut   = 1'b1;
                  nPhase = PH_IDLE;
                end
              end
              MD_RATE: begin
                if (isOne) begin
                  ctl.load = 1'b1;
                  nOut     = 1'b1;
                end else begin
                  ctl.dec = 1'b1;
                  if (isTwo) nOut = 1'b0;
                end
              end
              MD_SQUARE: begin
                if (isTwo) begin
                  ctl.load      = 1'b1;
                  ctl.highPhase = ~outReg;
                  nOut          = ~outReg;
                end else begin
                  ctl.dec = 1'b1;
                end
              end
              default: begin
                ctl.dec = 1'b1;
                if (isOne) begin
                  nOut   = 1'b0;
                  nPhase = PH_PULSE;
                end
              end
            endcase
          end
          PH_PULSE: begin
            nOut   = 1'b1;
            nPhase = PH_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      gatePrev <= 1'b0;
      bytePtr  <= 1'b0;
      armed    <= 1'b0;
      trigPend <= 1'b0;
      outReg   <= 1'b0;
      curMode  <= MD_TERM;
      phase    <= PH_IDLE;
    end else begin
      clkPrev  <= cntClkIn;
      gatePrev <= gateIn;
      armed    <= nArmed;
      trigPend <= nTrig;
      outReg   <= nOut;
      phase    <= nPhase;
      if (modeAccept) begin
        curMode <= modeE'(modeSel);
        bytePtr <= 1'b0;
      end else if (cntWr) begin
        bytePtr <= ~bytePtr;
      end
    end
  end

  assign outLevel = outReg;

  AST_TERM_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MD_TERM) && outReg && !modeWr && !cntWr |=> outReg); // R3
  AST_ONESHOT_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MD_ONESHOT) && outReg && !tick && !modeWr |=> outReg); // R5
  AST_RATE_LOW_ONE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MD_RATE) && !outReg && tick && gateIn && !modeWr |=> outReg); // R6
  AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ((curMode == MD_SWSTROBE) || (curMode == MD_HWSTROBE)) && !outReg && tick
      && !modeWr && !cntWr |=> outReg); // R8
  AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    modeWr && (modeSel > 3'd5) |=> $stable(curMode) && $stable(outReg)); // R11
endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntClkIn,
  input  logic              gateIn,
  input  logic              modeWr,
  input  logic [2:0]        modeSel,
  input  logic              cntWr,
  input  logic [BYTE_W-1:0] cntByte,
  output logic              cntOut
);
  dpCtlT            ctl;
  logic             counterTick, isOne, isTwo;
  logic [CNT_W-1:0] countVal;

  ictr_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cntClkIn (cntClkIn),
    .gateIn   (gateIn),
    .modeWr   (modeWr),
    .modeSel  (modeSel),
    .cntWr    (cntWr),
    .isOne    (isOne),
    .isTwo    (isTwo),
    .ctl      (ctl),
    .tick     (counterTick),
    .outLevel (cntOut)
  );

  ictr_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .byteIn   (cntByte),
    .countVal (countVal),
    .isOne    (isOne),
    .isTwo    (isTwo)
  );

  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !counterTick |=> $stable(countVal)); // R2
endmodule

// File: tb/ictr_channel_tb.sv
module ictr_channel_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntClkIn = 1'b0;
  logic       gateIn = 1'b1;
  logic       modeWr = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic       cntWr = 1'b0;
  logic [7:0] cntByte = 8'd0;
  logic       cntOut;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ictr_channel dut_i (
    .clk(clk), .rstN(rstN), .cntClkIn(cntClkIn), .gateIn(gateIn),
    .modeWr(modeWr), .modeSel(modeSel), .cntWr(cntWr), .cntByte(cntByte),
    .cntOut(cntOut)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (cntOut !== exp) begin
      errors++;
      $display("FAIL %s: cntOut got %b expected %b at %0t", req, cntOut, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk) cntClkIn = 1'b1;
    @(negedge clk) cntClkIn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk) begin modeWr = 1'b1; modeSel = m; end
    @(negedge clk) modeWr = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk) begin cntWr = 1'b1; cntByte = b; end
    @(negedge clk) cntWr = 1'b0;
  endtask

  task automatic writeCount(input logic [15:0] v);
    writeByte(v[7:0]);
    writeByte(v[15:8]);
  endtask

  task automatic gateFall();
    @(negedge clk) gateIn = 1'b0;
    @(negedge clk) gateIn = 1'b1;
  endtask

  task automatic testReset();
    check("R1 reset", 1'b0);
    ticks(3);
    check("R1 ticks after reset", 1'b0);
  endtask

  task automatic testMode0();
    setMode(3'd0);
    writeCount(16'd5);
    check("R3 low after write", 1'b0);
    ticks(5);
    check("R3 before terminal", 1'b0);
    tick();
    check("R3 terminal", 1'b1);
    ticks(4);
    check("R3 stays high", 1'b1);
  endtask

  task automatic testCollision();
    setMode(3'd0);
    writeByte(8'd2);
    @(negedge clk) begin cntWr = 1'b1; cntByte = 8'd0; cntClkIn = 1'b1; end
    @(negedge clk) begin cntWr = 1'b0; cntClkIn = 1'b0; end
    ticks(2);
    check("R2 coincident tick not used", 1'b0);
    tick();
    check("R2 load after write", 1'b1);
    writeByte(8'd1);
    ticks(3);
    check("R2 low byte alone no effect", 1'b1);
  endtask

  task automatic testGate0();
    setMode(3'd0);
    writeCount(16'd3);
    tick();
    gateIn = 1'b0;
    ticks(5);
    check("R4 gate low holds mode 0", 1'b0);
    gateIn = 1'b1;
    ticks(2);
    check("R4 resumed", 1'b0);
    tick();
    check("R4 terminal after resume", 1'b1);
  endtask

  task automatic testMode1();
    setMode(3'd1);
    check("R5 high after mode write", 1'b1);
    writeCount(16'd3);
    ticks(3);
    check("R5 no trigger no start", 1'b1);
    gateFall();
    check("R5 trigger alone", 1'b1);
    tick();
    check("R5 low on load", 1'b0);
    ticks(2);
    check("R5 still low", 1'b0);
    tick();
    check("R5 high at end", 1'b1);
    ticks(2);
    check("R5 stays high", 1'b1);
  endtask

  task automatic testRetrigger();
    setMode(3'd1);
    writeCount(16'd3);
    gateFall();
    tick();
    tick();
    gateFall();
    tick();
    check("R12 low after retrigger", 1'b0);
    ticks(2);
    check("R12 interval restarted", 1'b0);
    tick();
    check("R12 end of restarted interval", 1'b1);
  endtask

  task automatic testMode2();
    setMode(3'd2);
    writeCount(16'd4);
    tick();
    check("R6 high after load", 1'b1);
    ticks(2);
    check("R6 high mid period", 1'b1);
    tick();
    check("R6 low at count 1", 1'b0);
    tick();
    check("R6 high after one tick", 1'b1);
    gateIn = 1'b0;
    ticks(5);
    check("R4 gate low holds mode 2", 1'b1);
    gateIn = 1'b1;
    ticks(2);
    check("R6 second period mid", 1'b1);
    tick();
    check("R6 second pulse", 1'b0);
    tick();
    check("R6 second pulse ends", 1'b1);
  endtask

  task automatic testMode3();
    setMode(3'd3);
    writeCount(16'd4);
    tick();
    check("R7 even high start", 1'b1);
    tick();
    check("R7 even high half", 1'b1);
    tick();
    check("R7 even toggle low", 1'b0);
    tick();
    check("R7 even low half", 1'b0);
    tick();
    check("R7 even toggle high", 1'b1);
    writeCount(16'd5);
    tick();
    ticks(2);
    check("R7 odd high 3 ticks", 1'b1);
    tick();
    check("R7 odd toggle low", 1'b0);
    tick();
    check("R7 odd low 2 ticks", 1'b0);
    tick();
    check("R7 odd toggle high", 1'b1);
    ticks(2);
    check("R7 odd high again", 1'b1);
    tick();
    check("R7 odd low again", 1'b0);
  endtask

  task automatic testMode4();
    setMode(3'd4);
    writeCount(16'd3);
    tick();
    ticks(2);
    check("R8 high before zero", 1'b1);
    tick();
    check("R8 strobe low", 1'b0);
    tick();
    check("R8 strobe one tick", 1'b1);
    ticks(4);
    check("R8 no repeat", 1'b1);
  endtask

  task automatic testMode5();
    setMode(3'd5);
    writeCount(16'd2);
    ticks(3);
    check("R9 waits for trigger", 1'b1);
    gateFall();
    tick();
    tick();
    check("R9 high before zero", 1'b1);
    tick();
    check("R9 strobe low", 1'b0);
    tick();
    check("R9 strobe ends", 1'b1);
  endtask

  task automatic testBadMode();
    setMode(3'd0);
    writeCount(16'd4);
    tick();
    tick();
    setMode(3'd6);
    check("R11 code 6 ignored", 1'b0);
    tick();
    setMode(3'd7);
    check("R11 code 7 ignored", 1'b0);
    tick();
    check("R11 count carried on", 1'b0);
    tick();
    check("R11 terminal as before", 1'b1);
  endtask

  task automatic testZero();
    setMode(3'd0);
    writeCount(16'd0);
    ticks(65536);
    check("R10 zero still counting", 1'b0);
    tick();
    check("R10 zero equals 65536", 1'b1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMode0();
    testCollision();
    testGate0();
    testMode1();
    testRetrigger();
    testMode2();
    testMode3();
    testMode4();
    testMode5();
    testBadMode();
    testZero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule